// File: doc/BRIEF.md
# I2C Target Front End with Mismatch Clock Gating

This block is the serial front end that sits between a two-wire bus and the register core of a two-channel converter. It oversamples SCL and SDA on the system clock and recognises START, repeated START and STOP. It shifts in a 7-bit address and acknowledges its own address by pulling SDA low through an open-drain driver. It then passes each written byte to the core with its position in the frame, or fetches bytes from the core and shifts them out MSB first when the master reads.

The own address is a 6-bit parameter extended by one select pin, which is captured while reset is asserted. The general call address and any 10-bit header are never acknowledged. A byte that does not hit the own address moves the block into a quiet state. In that state the core clock-enable is low and the bus is ignored until the next START. A repeated START is accepted at any point, so a write that selects a register can be followed by a read phase.

States: IDLE (bus free or frame finished), ADDR (address byte shifting), ADDR_ACK (own-address acknowledge), WR (write byte shifting), WR_ACK (write acknowledge), RD (read byte driving), RD_ACK (master acknowledge slot) and IGNORE (after a mismatch). Transitions: any state goes to ADDR on START. Any state except IGNORE goes to IDLE on STOP. ADDR goes to ADDR_ACK on a hit, or to IGNORE on a miss, at the eighth SCL fall. ADDR_ACK goes to RD or WR by the R/W bit at the ninth fall. WR goes to WR_ACK after eight bits, and WR_ACK returns to WR. RD goes to RD_ACK after eight bits. RD_ACK goes back to RD on a master ACK, or to IDLE on a NACK.

Top module: `i2c_tgt_gate`

## Requirements
- R1: SDA falling while SCL is high (START) enters the address phase from any state, including mid-frame (repeated START), and restarts the byte index at 0.
- R2: An address byte whose upper 7 bits equal {ADDR_HI, latched addr_sel} is acknowledged: sda_drive_low is high during the high phase of the ninth SCL clock, and frame_start pulses once.
- R3: The general call address 7'b0000000 is never acknowledged and produces no frame_start, rx_valid or rd_req.
- R4: After a non-matching address byte, including any 10-bit header 7'b11110xx, core_clk_en is low, SDA is never pulled, and no core strobe occurs; a STOP does not reopen the gate, only the next START does.
- R5: Each byte written after an acknowledged address is presented MSB first on rx_byte with a one-cycle rx_valid pulse and rx_index counting 0, 1, ... since the last START, and it is acknowledged.
- R6: With R/W = 1 (bit 0 of the address byte), rd_req pulses with rd_index 0 at the end of the address byte, and the core's reply is driven MSB first starting right after the address ACK. SDA drive changes only while SCL is low.
- R7: When the master acknowledges a read byte, rd_req pulses again with the next rd_index, and that byte is sent.
- R8: When the master NACKs a read byte, SDA stays released and no further rd_req occurs until the next START or STOP.
- R9: SDA rising while SCL is high (STOP) pulses frame_stop once for a frame whose address was acknowledged, and leaves SDA released.
- R10: addr_sel is captured only during reset; changing it afterwards does not change the address that is acknowledged.
- R11: Out of reset, SDA is released, core_clk_en is high and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Address low bit, captured during reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| core_clk_en | output | 1 | Clock-enable gate for the register core |
| frame_start | output | 1 | One-cycle pulse when the own address is acknowledged |
| frame_stop | output | 1 | One-cycle pulse on STOP ending an acknowledged frame |
| rx_valid | output | 1 | One-cycle strobe for a received write byte |
| rx_byte | output | 8 | Received write byte |
| rx_index | output | IDX_W | Position of rx_byte since the last START |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_index | output | IDX_W | Position of the requested read byte |
| rd_resp_valid | input | 1 | Core reply strobe for rd_req |
| rd_resp_data | input | 8 | Core reply byte |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except to form START and STOP. They also assume that each SCL phase lasts longer than the three-cycle synchroniser and edge latency, so that a change of the open-drain driver always falls inside the low phase. They assume the core answers each rd_req within a few cycles, well before the next SCL fall. The stimulus uses a bus clock with 10-cycle quarter periods and changes SDA only a full quarter after SCL falls. Its core model answers one cycle after each request.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_d, sda_d, scl_now;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_in;
                    sda_ff <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_in};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_now = scl_ff[STAGES-1];
    assign sda_s   = sda_ff[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_now;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign start_det = scl_now & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_now & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_W-2:0] ADDR_HI = 6'b011100,
    parameter int                IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              rd_resp_valid,
    input  logic [BYTE_W-1:0] rd_resp_data,
    output logic              sda_drive_low,
    output logic              core_clk_en,
    output logic              frame_start,
    output logic              frame_stop,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [IDX_W-1:0]  rx_index,
    output logic              rd_req,
    output logic [IDX_W-1:0]  rd_index
);
    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(BYTE_W - 1);
    localparam logic [4:0]       TENBIT_HDR = 5'b11110;

    tgt_state_t          state_q, state_d;
    logic [CNT_W-1:0]    bitcnt_q;
    logic                byte_done_q;
    logic [BYTE_W-1:0]   sh_q, tx_q;
    logic [IDX_W-1:0]    idx_q;
    logic                addr_lat_q, active_q, mack_q;
    logic [ADDR_W-1:0]   rx_addr, own_addr;
    logic                addr_hit;

    assign own_addr = {ADDR_HI, addr_lat_q};
    assign rx_addr  = sh_q[BYTE_W-1 -: ADDR_W];
    assign addr_hit = (rx_addr == own_addr) && (rx_addr != '0)
                   && (rx_addr[ADDR_W-1 -: 5] != TENBIT_HDR);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = (state_q == ST_IGNORE) ? ST_IGNORE : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:     if (scl_fall && byte_done_q)
                                 state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = sh_q[0] ? ST_RD : ST_WR;
                ST_WR:       if (scl_fall && byte_done_q) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR;
                ST_RD:       if (scl_fall && bitcnt_q == LAST_BIT) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = mack_q ? ST_RD : ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lat_q  <= addr_sel;
            bitcnt_q    <= '0;
            byte_done_q <= 1'b0;
            sh_q        <= '0;
            tx_q        <= '1;
            idx_q       <= '0;
            active_q    <= 1'b0;
            mack_q      <= 1'b0;
            frame_start <= 1'b0;
            frame_stop  <= 1'b0;
            rx_valid    <= 1'b0;
            rx_byte     <= '0;
            rx_index    <= '0;
            rd_req      <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            frame_stop  <= 1'b0;
            rx_valid    <= 1'b0;
            rd_req      <= 1'b0;
            if (start_det) begin
                bitcnt_q    <= '0;
                byte_done_q <= 1'b0;
                idx_q       <= '0;
            end else if (stop_det) begin
                bitcnt_q    <= '0;
                byte_done_q <= 1'b0;
                frame_stop  <= active_q;
                active_q    <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            sh_q     <= {sh_q[BYTE_W-2:0], sda_s};
                            bitcnt_q <= bitcnt_q + 1'b1;
                            if (bitcnt_q == LAST_BIT) byte_done_q <= 1'b1;
                        end
                        if (scl_fall && byte_done_q) begin
                            byte_done_q <= 1'b0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    frame_start <= 1'b1;
                                    active_q    <= 1'b1;
                                    rd_req      <= sh_q[0];
                                end
                            end else begin
                                rx_valid <= 1'b1;
                                rx_byte  <= sh_q;
                                rx_index <= idx_q;
                                if (idx_q != '1) idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (rd_resp_valid) tx_q <= rd_resp_data;
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (bitcnt_q == LAST_BIT) begin
                                bitcnt_q <= '0;
                                if (idx_q != '1) idx_q <= idx_q + 1'b1;
                            end else begin
                                bitcnt_q <= bitcnt_q + 1'b1;
                                tx_q     <= {tx_q[BYTE_W-2:0], 1'b1};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                            rd_req <= ~sda_s;
                        end
                        if (rd_resp_valid) tx_q <= rd_resp_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs decoded from registered state
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_drive_low = 1'b1;
            ST_RD:                  sda_drive_low = ~tx_q[BYTE_W-1];
            default:                sda_drive_low = 1'b0;
        endcase
        core_clk_en = (state_q != ST_IGNORE);
        rd_index    = idx_q;
    end
endmodule

// File: rtl/i2c_tgt_gate.sv
module i2c_tgt_gate
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_W-2:0] ADDR_HI   = 6'b011100,
    parameter int                IDX_W     = 3,
    parameter int                SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    output logic              core_clk_en,
    output logic              frame_start,
    output logic              frame_stop,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [IDX_W-1:0]  rx_index,
    output logic              rd_req,
    output logic [IDX_W-1:0]  rd_index,
    input  logic              rd_resp_valid,
    input  logic [BYTE_W-1:0] rd_resp_data
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.ADDR_HI(ADDR_HI), .IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_sel      (addr_sel),
        .sda_s         (sda_s),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .rd_resp_valid (rd_resp_valid),
        .rd_resp_data  (rd_resp_data),
        .sda_drive_low (sda_drive_low),
        .core_clk_en   (core_clk_en),
        .frame_start   (frame_start),
        .frame_stop    (frame_stop),
        .rx_valid      (rx_valid),
        .rx_byte       (rx_byte),
        .rx_index      (rx_index),
        .rd_req        (rd_req),
        .rd_index      (rd_index)
    );
endmodule

// File: rtl/i2c_tgt_gate_chk.sv
module i2c_tgt_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_drive_low,
    input logic core_clk_en,
    input logic frame_start,
    input logic frame_stop,
    input logic rx_valid,
    input logic rd_req
);
    assert_gate_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> (!sda_drive_low && !rx_valid && !rd_req && !frame_start));

    assert_drive_in_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_in);

    assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_rdreq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    assert_start_gate_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> core_clk_en);

    assert_stop_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stop |-> !sda_drive_low);

    assert_stop_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stop |=> !frame_stop);
endmodule

bind i2c_tgt_gate i2c_tgt_gate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .sda_drive_low (sda_drive_low),
    .core_clk_en   (core_clk_en),
    .frame_start   (frame_start),
    .frame_stop    (frame_stop),
    .rx_valid      (rx_valid),
    .rd_req        (rd_req)
);

// File: tb/i2c_tgt_gate_bench.sv
module i2c_tgt_gate_bench;
    localparam int Q     = 10;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low, core_clk_en, frame_start, frame_stop, rx_valid, rd_req;
    logic [7:0] rx_byte;
    logic [IDX_W-1:0] rx_index, rd_index;
    logic rd_resp_valid = 1'b0;
    logic [7:0] rd_resp_data = 8'h00;
    logic sda_bus;

    int checks = 0;
    int fails = 0;
    int fs_cnt = 0, fp_cnt = 0, rq_cnt = 0, rx_cnt = 0;
    logic [7:0] rx_log_b [8];
    int         rx_log_i [8];
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive_low;

    i2c_tgt_gate #(.IDX_W(IDX_W)) u_i2c_tgt_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_sel      (addr_sel),
        .scl_in        (scl_m),
        .sda_in        (sda_bus),
        .sda_drive_low (sda_drive_low),
        .core_clk_en   (core_clk_en),
        .frame_start   (frame_start),
        .frame_stop    (frame_stop),
        .rx_valid      (rx_valid),
        .rx_byte       (rx_byte),
        .rx_index      (rx_index),
        .rd_req        (rd_req),
        .rd_index      (rd_index),
        .rd_resp_valid (rd_resp_valid),
        .rd_resp_data  (rd_resp_data)
    );

    function automatic logic [7:0] core_val(input int idx);
        return 8'(8'hC3 + idx * 8'h11);
    endfunction

    // core model and strobe observers, away from the active edge
    always @(negedge clk) begin
        rd_resp_valid <= rd_req;
        rd_resp_data  <= core_val(int'(rd_index));
        if (frame_start) fs_cnt <= fs_cnt + 1;
        if (frame_stop)  fp_cnt <= fp_cnt + 1;
        if (rd_req)      rq_cnt <= rq_cnt + 1;
        if (rx_valid) begin
            if (rx_cnt < 8) begin
                rx_log_b[rx_cnt] <= rx_byte;
                rx_log_i[rx_cnt] <= int'(rx_index);
            end
            rx_cnt <= rx_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic smp);
        sda_m = b;  wq(Q);
        scl_m = 1'b1; wq(Q);
        smp = sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
        bus_bit(~master_ack, s);
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        chk("R11 sda released", int'(sda_drive_low), 0);
        chk("R11 gate open", int'(core_clk_en), 1);
        chk("R11 no strobes", int'(rx_valid | rd_req | frame_start | frame_stop), 0);
    endtask

    task automatic t_write();
        logic ak;
        int fs0, fp0;
        fs0 = fs_cnt; fp0 = fp_cnt;
        addr_sel = 1'b0;  // R10: change after reset must have no effect
        bus_start();
        send_byte(8'h72, ak);
        chk("R2 R10 own address acked", int'(ak), 1);
        chk("R2 frame_start once", fs_cnt - fs0, 1);
        send_byte(8'h3C, ak);
        chk("R5 byte0 acked", int'(ak), 1);
        send_byte(8'h81, ak);
        chk("R5 byte1 acked", int'(ak), 1);
        chk("R5 rx count", rx_cnt, 2);
        chk("R5 byte0 value", int'(rx_log_b[0]), 'h3C);
        chk("R5 byte0 index", rx_log_i[0], 0);
        chk("R5 byte1 value", int'(rx_log_b[1]), 'h81);
        chk("R5 byte1 index", rx_log_i[1], 1);
        bus_stop();
        wq(4);
        chk("R9 frame_stop once", fp_cnt - fp0, 1);
        chk("R9 sda released", int'(sda_drive_low), 0);
    endtask

    task automatic t_read();
        logic ak, s;
        logic [7:0] d;
        int rx0, fp0, rq0;
        rx0 = rx_cnt; fp0 = fp_cnt; rq0 = rq_cnt;
        bus_start();
        send_byte(8'h72, ak);
        send_byte(8'hF1, ak);
        chk("R5 command byte index 0", rx_log_i[rx0], 0);
        bus_rstart();
        send_byte(8'h73, ak);
        chk("R1 repeated start read address acked", int'(ak), 1);
        recv_byte(1'b1, d);
        chk("R6 first read byte (index 0)", int'(d), int'(core_val(0)));
        recv_byte(1'b0, d);
        chk("R7 second read byte (index 1)", int'(d), int'(core_val(1)));
        chk("R7 two read requests", rq_cnt - rq0, 2);
        ak = 1'b0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            if (!s) ak = 1'b1;
        end
        chk("R8 sda released after nack", int'(ak), 0);
        chk("R8 no request after nack", rq_cnt - rq0, 2);
        bus_stop();
        wq(4);
        chk("R9 frame_stop after read", fp_cnt - fp0, 1);
    endtask

    task automatic t_gencall();
        logic ak;
        int fs0, fp0, rx0, rq0;
        fs0 = fs_cnt; fp0 = fp_cnt; rx0 = rx_cnt; rq0 = rq_cnt;
        bus_start();
        send_byte(8'h00, ak);
        chk("R3 general call not acked", int'(ak), 0);
        chk("R4 gate closed after general call", int'(core_clk_en), 0);
        send_byte(8'h55, ak);
        chk("R4 data ignored not acked", int'(ak), 0);
        chk("R3 no core strobes", (fs_cnt - fs0) + (rx_cnt - rx0) + (rq_cnt - rq0), 0);
        bus_stop();
        wq(4);
        chk("R4 stop keeps gate closed", int'(core_clk_en), 0);
        chk("R4 no frame_stop", fp_cnt - fp0, 0);
        sda_m = 1'b0; wq(Q);
        chk("R1 start reopens gate", int'(core_clk_en), 1);
        scl_m = 1'b0; wq(Q);
        bus_stop();
        wq(4);
    endtask

    task automatic t_mismatch(input logic [7:0] ab, input string tag);
        logic ak;
        int fs0;
        fs0 = fs_cnt;
        bus_start();
        send_byte(ab, ak);
        chk({tag, " not acked"}, int'(ak), 0);
        chk({tag, " gate closed"}, int'(core_clk_en), 0);
        chk({tag, " no frame_start"}, fs_cnt - fs0, 0);
        bus_stop();
        wq(4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_write();
        t_read();
        t_gencall();
        t_mismatch(8'h70, "R10 R4 unlatched select value");
        t_mismatch(8'hF0, "R4 ten-bit header");
        finish_run();
    end
endmodule